// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This combinational unit adds or subtracts two operands held in signed-magnitude form and returns a signed-magnitude result of the same width. The top bit of each word is the sign (1 for negative) and the lower bits are an unsigned magnitude. A subtract control flips the sign of the second operand. The two operands are then combined either by adding magnitudes, when the signs agree, or by taking the smaller magnitude from the larger, when they do not.

Before a subtraction the magnitudes are compared. When the second operand is larger, the two are swapped so that the magnitude path never borrows. The sign is attached after the magnitude has been formed. A result whose magnitude is zero always has its sign bit cleared. An overflow flag reports a magnitude sum that does not fit. A zero flag reports a zero magnitude.

Top module: `sm_addsub`

## Requirements
- R1: Bit N-1 of each operand and of the result is the sign (1 means negative). Bits N-2..0 hold the unsigned magnitude.
- R2: When the sign of A equals the effective sign of B, the result magnitude is |A|+|B| and the result sign is that common sign.
- R3: With sub_en=1 the effective sign of B is its sign bit inverted, so the result equals A minus B. With sub_en=0 it is the sign bit unchanged.
- R4: When the effective signs differ and |A| >= |B|, the result magnitude is |A|-|B| and the sign is A's sign.
- R5: When the effective signs differ and |B| > |A|, the operands are swapped. The result magnitude is |B|-|A| and the sign is B's effective sign.
- R6: A result with zero magnitude always carries sign bit 0. This includes -0 combined with -0 and the sum of equal magnitudes with opposite signs.
- R7: ovf is 1 exactly when a same-sign magnitude sum reaches 2^(N-1). In that case the magnitude output is the sum modulo 2^(N-1).
- R8: zero is 1 exactly when result bits N-2..0 are all 0.
- R9: ovf is 0 whenever the effective signs differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First operand, signed magnitude |
| opnd_b | input | N | Second operand, signed magnitude |
| sub_en | input | 1 | 1 selects A-B, 0 selects A+B |
| result | output | N | Signed-magnitude result |
| ovf | output | 1 | Magnitude sum overflowed |
| zero | output | 1 | Result magnitude is zero |

## Verification
The checker tests four properties on every input change. A zero result never carries a set sign bit. The zero flag matches the magnitude bits. Overflow appears only when the effective signs agree. A result whose signs differ is never larger than the larger operand magnitude. The exact magnitude and sign produced by the swap, the wrap value after overflow, and the handling of both zero encodings are not covered by these properties. They are shown only by the bench, which runs every operand pair at N=4 in both modes and random pairs at N=8, and compares each result with an integer model.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic {
        PATH_ALIKE  = 1'b0,
        PATH_UNLIKE = 1'b1
    } path_e;

    typedef struct packed {
        logic  sign_a;
        logic  sign_b;
        path_e path;
        logic  swap;
    } ctl_t;

    function automatic logic eff_sign(input logic sign, input logic sub);
        return sign ^ sub;
    endfunction

    function automatic path_e pick_path(input logic sa, input logic sb);
        return (sa == sb) ? PATH_ALIKE : PATH_UNLIKE;
    endfunction

endpackage

// File: rtl/sm_split.sv
module sm_split
    import sm_pkg::*;
#(
    parameter int N = 8,
    localparam int M = N - 1
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    input  logic         sub_en,
    output logic [M-1:0] mag_a,
    output logic [M-1:0] mag_b,
    output logic         sign_a,
    output logic         sign_b,
    output path_e        path
);
    always_comb begin
        mag_a  = opnd_a[M-1:0];
        mag_b  = opnd_b[M-1:0];
        sign_a = opnd_a[N-1];
        sign_b = eff_sign(opnd_b[N-1], sub_en);
        path   = pick_path(sign_a, sign_b);
    end
endmodule

// File: rtl/sm_order.sv
module sm_order #(
    parameter int M = 7
) (
    input  logic [M-1:0] mag_a,
    input  logic [M-1:0] mag_b,
    output logic [M-1:0] mag_big,
    output logic [M-1:0] mag_small,
    output logic         swap
);
    always_comb begin
        swap = (mag_b > mag_a);
        if (swap) begin
            mag_big   = mag_b;
            mag_small = mag_a;
        end else begin
            mag_big   = mag_a;
            mag_small = mag_b;
        end
    end
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
    parameter int M = 7
) (
    input  logic [M-1:0] op_x,
    input  logic [M-1:0] op_y,
    input  logic         do_sub,
    output logic [M-1:0] mag_out,
    output logic         carry_out
);
    logic [M:0]   cy;
    logic [M-1:0] y_adj;

    assign cy[0] = do_sub;
    assign y_adj = op_y ^ {M{do_sub}};

    for (genvar i = 0; i < M; i++) begin : g_bit
        logic p;
        assign p          = op_x[i] ^ y_adj[i];
        assign mag_out[i] = p ^ cy[i];
        assign cy[i+1]    = (op_x[i] & y_adj[i]) | (p & cy[i]);
    end

    assign carry_out = cy[M];
endmodule

// File: rtl/sm_pack.sv
module sm_pack
    import sm_pkg::*;
#(
    parameter int N = 8,
    localparam int M = N - 1
) (
    input  ctl_t         ctl,
    input  logic [M-1:0] mag,
    input  logic         carry,
    output logic [N-1:0] result,
    output logic         ovf,
    output logic         zero
);
    logic raw_sign;
    logic mag_zero;

    always_comb begin
        if (ctl.path == PATH_ALIKE) begin
            raw_sign = ctl.sign_a;
        end else begin
            raw_sign = ctl.swap ? ctl.sign_b : ctl.sign_a;
        end
        mag_zero = (mag == '0);
        result   = {raw_sign & ~mag_zero, mag};
        ovf      = (ctl.path == PATH_ALIKE) & carry;
        zero     = mag_zero;
    end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    input  logic         sub_en,
    output logic [N-1:0] result,
    output logic         ovf,
    output logic         zero
);
    localparam int M = N - 1;

    logic [M-1:0] mag_a, mag_b, mag_big, mag_small;
    logic [M-1:0] op_x, op_y, mag_res;
    logic         sign_a, sign_b, swap, carry;
    path_e        path;
    ctl_t         ctl;

    sm_split #(.N(N)) u_split (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .sub_en (sub_en),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .sign_a (sign_a),
        .sign_b (sign_b),
        .path   (path)
    );

    sm_order #(.M(M)) u_order (
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .mag_big   (mag_big),
        .mag_small (mag_small),
        .swap      (swap)
    );

    always_comb begin
        if (path == PATH_ALIKE) begin
            op_x = mag_a;
            op_y = mag_b;
        end else begin
            op_x = mag_big;
            op_y = mag_small;
        end
        ctl.sign_a = sign_a;
        ctl.sign_b = sign_b;
        ctl.path   = path;
        ctl.swap   = swap;
    end

    sm_mag_unit #(.M(M)) u_mag (
        .op_x      (op_x),
        .op_y      (op_y),
        .do_sub    (path == PATH_UNLIKE),
        .mag_out   (mag_res),
        .carry_out (carry)
    );

    sm_pack #(.N(N)) u_pack (
        .ctl    (ctl),
        .mag    (mag_res),
        .carry  (carry),
        .result (result),
        .ovf    (ovf),
        .zero   (zero)
    );
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] opnd_a,
    input logic [N-1:0] opnd_b,
    input logic         sub_en,
    input logic [N-1:0] result,
    input logic         ovf,
    input logic         zero
);
    localparam int M = N - 1;

    logic         b_eff;
    logic [M-1:0] big;

    always_comb begin
        b_eff = opnd_b[N-1] ^ sub_en;
        big   = (opnd_a[M-1:0] > opnd_b[M-1:0]) ? opnd_a[M-1:0] : opnd_b[M-1:0];
        if (!$isunknown({opnd_a, opnd_b, sub_en})) begin
            AST_ZERO_SIGN: assert (!zero || !result[N-1]);                        // R6
            AST_ZERO_FLAG: assert (zero == (result[M-1:0] == '0));                // R8
            AST_OVF_ALIKE: assert (!ovf || (opnd_a[N-1] == b_eff));               // R9
            AST_DIFF_BOUND: assert ((opnd_a[N-1] == b_eff) || (result[M-1:0] <= big)); // R4
        end
    end
endmodule

bind sm_addsub sm_addsub_chk #(.N(N)) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .sub_en (sub_en),
    .result (result),
    .ovf    (ovf),
    .zero   (zero)
);

// File: tb/sim_sm_addsub.sv
module sim_sm_addsub;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [3:0] a4, b4, r4;
    logic       s4, o4, z4;
    logic [7:0] a8, b8, r8;
    logic       s8, o8, z8;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    sm_addsub #(.N(4)) u0 (.opnd_a(a4), .opnd_b(b4), .sub_en(s4),
                           .result(r4), .ovf(o4), .zero(z4));
    sm_addsub #(.N(8)) u1 (.opnd_a(a8), .opnd_b(b8), .sub_en(s8),
                           .result(r8), .ovf(o8), .zero(z8));

    // expected {ovf, zero, result} packed at bits w+1, w, w-1..0
    function automatic int ref_model(int w, int a, int b, int sub);
        int m   = w - 1;
        int lim = 1 << m;
        int va  = a & (lim - 1);
        int vb  = b & (lim - 1);
        int r, ar, mg, sg, o;
        if (((a >> m) & 1) == 1) va = -va;
        if (((b >> m) & 1) == 1) vb = -vb;
        if (sub != 0) vb = -vb;
        r  = va + vb;
        ar = (r < 0) ? -r : r;
        o  = (ar >= lim) ? 1 : 0;
        mg = ar % lim;
        sg = (r < 0 && mg != 0) ? 1 : 0;
        return (o << (w + 1)) | (((mg == 0) ? 1 : 0) << w) | (sg << m) | mg;
    endfunction

    function automatic string tag_of(int w, int a, int b, int sub);
        int m  = w - 1;
        int sa = (a >> m) & 1;
        int sb = ((b >> m) & 1) ^ sub;
        int ma = a & ((1 << m) - 1);
        int mb = b & ((1 << m) - 1);
        int e  = ref_model(w, a, b, sub);
        if (((e >> (w + 1)) & 1) == 1) return "R7";
        if (((e >> w) & 1) == 1)       return "R6";
        if (sa == sb)                  return (sub != 0) ? "R3" : "R2";
        if (mb > ma)                   return "R5";
        return "R4";
    endfunction

    task automatic judge(string tag, int w, int a, int b, int sub, int got);
        int exp = ref_model(w, a, b, sub);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s w=%0d a=%h b=%h sub=%0d got=%h exp=%h",
                     tag, w, a, b, sub, got, exp);
        end
    endtask

    task automatic run4(string tag, int a, int b, int sub);
        @(posedge clk);
        a4 = a[3:0]; b4 = b[3:0]; s4 = sub[0];
        @(negedge clk);
        judge(tag, 4, a, b, sub, {26'd0, o4, z4, r4});
    endtask

    task automatic run8(string tag, int a, int b, int sub);
        @(posedge clk);
        a8 = a[7:0]; b8 = b[7:0]; s8 = sub[0];
        @(negedge clk);
        judge(tag, 8, a, b, sub, {22'd0, o8, z8, r8});
    endtask

    initial begin
        int unused_seed;
        a4 = '0; b4 = '0; s4 = 1'b0;
        a8 = '0; b8 = '0; s8 = 1'b0;
        unused_seed = $urandom(32'h5eed_0404);
        @(negedge clk);
        // initial state with all-zero inputs: R8 zero flag, R6 positive zero
        judge("R8", 4, 0, 0, 0, {26'd0, o4, z4, r4});
        judge("R8", 8, 0, 0, 0, {22'd0, o8, z8, r8});

        // directed corners at N=4 (sign bit 3, magnitude bits 2..0)
        run4("R1", 4'h3, 4'h2, 0);   // +3 + +2 = +5
        run4("R2", 4'hB, 4'hA, 0);   // -3 + -2 = -5
        run4("R3", 4'h3, 4'h2, 1);   // +3 - +2 = +1
        run4("R5", 4'h2, 4'h3, 1);   // +2 - +3 = -1 via swap
        run4("R4", 4'h5, 4'hA, 0);   // +5 + -2 = +3
        run4("R6", 4'h8, 4'h8, 0);   // -0 + -0 -> +0
        run4("R6", 4'hD, 4'h5, 0);   // -5 + +5 -> +0
        run4("R7", 4'h7, 4'h1, 0);   // 7+1 wraps to 0, ovf
        run4("R7", 4'hF, 4'h7, 1);   // -7 - +7 wraps to -6, ovf
        run4("R9", 4'h7, 4'hF, 0);   // +7 + -7 no ovf
        run4("R8", 4'h4, 4'h4, 1);   // +4 - +4 zero

        // exhaustive N=4
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(tag_of(4, a, b, s), a, b, s);

        // random N=8 with a fixed seed, plus corners
        run8("R7", 8'h7F, 8'h7F, 0);
        run8("R5", 8'h01, 8'h7F, 1);
        run8("R6", 8'h80, 8'h00, 1);
        for (int i = 0; i < 800; i++) begin
            int a = int'($urandom % 256);
            int b = int'($urandom % 256);
            int s = int'($urandom % 2);
            run8(tag_of(8, a, b, s), a, b, s);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule